// File: doc/BRIEF.md
# Parallel DAC Port Write and Readback Sequencer

This block sits on the host side of a current-output DAC that has a parallel digital port. The port has an active-low select, a direction strobe (low writes, high reads back the DAC register) and a data bus of 8, 10 or 12 bits, with bit 0 as the least significant bit. The host issues one command at a time through a valid/ready port. A write command carries a code. A read command fetches the code the converter currently holds. Every timing limit of the port is a parameter in nanoseconds. Each one is turned into whole clock cycles by rounding up, so a nonzero limit always costs at least one cycle and a zero limit costs nothing.

The bus is split into a driven value, an output enable and a sampled input, so the pad ring can build the tristate. The sequencer keeps a shadow of the last code written. The shadow is zero after reset, which matches the cleared register inside the converter. Each readback returns the sampled code together with a flag that is set when the code differs from the shadow.

The controller has seven states:
- `ST_IDLE` goes to `ST_WR_PRE` or `ST_RD_PRE` when a command is accepted.
- `ST_WR_PRE` sets up direction and data, then goes to `ST_WR_LOW`.
- `ST_WR_LOW` holds the select low, then goes to `ST_WR_HOLD`.
- `ST_WR_HOLD` keeps direction and data after the select rises, then returns to `ST_IDLE`.
- `ST_RD_PRE` sets the direction high with the bus released, then goes to `ST_RD_LOW`.
- `ST_RD_LOW` holds the select low through the access time, then goes to `ST_RD_DONE`.
- `ST_RD_DONE` gives the response, then returns to `ST_IDLE`.

Every state lasts at least one cycle. On each return to `ST_IDLE` a gap counter is loaded, and no new command is accepted until that counter expires.

Top module: `dac_bus_ctrl`

## Requirements
- R1: After reset, `dac_cs_n`=1, `dac_rw`=1, `dac_db_oe`=0, `cmd_ready`=1 and `rsp_valid`=0. A readback issued before any write returns 0 with `rsp_mismatch`=0.
- R2: For a write (`cmd_write`=1), `dac_rw` goes low and `dac_db_oe` goes high at least one cycle before `dac_cs_n` falls. `dac_cs_n` then stays low for max(1, ceil(T_CS_LOW/P), ceil(T_DATA_SETUP/P)) cycles, which is 1 at the defaults. `dac_rw` and `dac_db_out` stay stable while the select is low, and `dac_rw` is still low in the cycle the select rises. The converter register receives the code.
- R3: For a read (`cmd_write`=0), `dac_rw` is high and `dac_db_oe` is low at least one cycle before `dac_cs_n` falls. The select stays low for max(ceil(T_CS_LOW/P), ceil(T_ACCESS/P)+1) cycles, which is 3 at the defaults. `dac_db_oe` is never high while the select is low with `dac_rw` high.
- R4: `rsp_valid` is high for exactly one cycle, the first cycle after `dac_cs_n` returns high at the end of a read. `rsp_data` equals the bus value in the last cycle the select was low, bit 0 least significant.
- R5: `rsp_mismatch` is 1 exactly when the code read back differs from the last code written, or from 0 if nothing has been written since reset.
- R6: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays low from that edge until the cycle has finished and the gap has expired.
- R7: When a read is followed at once by a waiting command, `dac_cs_n` stays high with `dac_db_oe` low for exactly 2+G cycles before the output enable rises. G = max(ceil(T_CS_HIGH/P), ceil(T_RELEASE/P)), so the count is 3 at the defaults. The device never drives the bus while `dac_db_oe` is high.
- R8: Limits convert by rounding up against `CLK_PERIOD_NS`. With P=5 ns and the other limits at their defaults, a write holds the select low for 2 cycles, a read for 6, and the read-to-write turnaround is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted on this edge when valid is also high |
| cmd_write | input | 1 | 1 = write the code, 0 = read back |
| cmd_data | input | DATA_W | Code to write |
| rsp_valid | output | 1 | One-cycle readback response strobe |
| rsp_data | output | DATA_W | Code read back |
| rsp_mismatch | output | 1 | Readback differs from the shadow of the last write |
| dac_cs_n | output | 1 | Active-low select to the converter |
| dac_rw | output | 1 | Direction strobe, high = readback |
| dac_db_out | output | DATA_W | Value driven onto the data bus |
| dac_db_oe | output | 1 | Host drive enable for the data bus |
| dac_db_in | input | DATA_W | Value sampled from the data bus |

## Verification
A phase timer left with the wrong count shows up as a select pulse of the wrong length on the very next command, and a read that closes too early captures unsettled data. A stale or wrongly updated shadow cannot be seen on writes. It appears only at the next readback, as a mismatch flag that disagrees with the written history. That is why every write is followed by a read, and why a deliberate corruption of the device register is included. A gap counter that expires early shows up as the host drive enable rising one or more cycles too soon after a read. The bench measures that as a shortened turnaround and as contention against the device's release window.

// File: rtl/dac_bus_pkg.sv
`timescale 1ns/1ps
package dac_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PRE,
        ST_WR_LOW,
        ST_WR_HOLD,
        ST_RD_PRE,
        ST_RD_LOW,
        ST_RD_DONE
    } bus_state_e;

    // Round a limit in ns up to whole clock cycles; zero stays zero.
    function automatic int ns_to_cyc(input int lim_ns, input int per_ns);
        if (lim_ns <= 0) return 0;
        return (lim_ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int value);
        int w;
        w = 1;
        while ((1 << w) <= value) w++;
        return w;
    endfunction

endpackage

// File: rtl/dac_bus_timer.sv
`timescale 1ns/1ps
// Loadable down counter; reports when it has reached zero.
module dac_bus_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dac_bus_readback.sv
`timescale 1ns/1ps
// Shadow of the last written code, readback capture and compare.
module dac_bus_readback #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] commit_data,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_mismatch
);

    logic [DATA_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (commit) begin
            shadow_q <= commit_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_mismatch <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_data     <= bus_data;
                rsp_mismatch <= (bus_data != shadow_q);
            end
        end
    end

endmodule

// File: rtl/dac_bus_ctrl.sv
`timescale 1ns/1ps
module dac_bus_ctrl
    import dac_bus_pkg::*;
#(
    parameter int DATA_W           = 12,
    parameter int CLK_PERIOD_NS    = 20,
    parameter int T_RW_SETUP_NS    = 0,
    parameter int T_RW_HOLD_NS     = 0,
    parameter int T_CS_LOW_NS      = 10,
    parameter int T_DATA_SETUP_NS  = 6,
    parameter int T_DATA_HOLD_NS   = 0,
    parameter int T_READ_SETUP_NS  = 5,
    parameter int T_CS_HIGH_NS     = 7,
    parameter int T_ACCESS_NS      = 25,
    parameter int T_RELEASE_NS     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_mismatch,
    output logic              dac_cs_n,
    output logic              dac_rw,
    output logic [DATA_W-1:0] dac_db_out,
    output logic              dac_db_oe,
    input  logic [DATA_W-1:0] dac_db_in
);

    // Limits in cycles
    localparam int CYC_RW_SU  = ns_to_cyc(T_RW_SETUP_NS,   CLK_PERIOD_NS);
    localparam int CYC_RW_HD  = ns_to_cyc(T_RW_HOLD_NS,    CLK_PERIOD_NS);
    localparam int CYC_CS_LO  = ns_to_cyc(T_CS_LOW_NS,     CLK_PERIOD_NS);
    localparam int CYC_D_SU   = ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS);
    localparam int CYC_D_HD   = ns_to_cyc(T_DATA_HOLD_NS,  CLK_PERIOD_NS);
    localparam int CYC_RD_SU  = ns_to_cyc(T_READ_SETUP_NS, CLK_PERIOD_NS);
    localparam int CYC_CS_HI  = ns_to_cyc(T_CS_HIGH_NS,    CLK_PERIOD_NS);
    localparam int CYC_ACC    = ns_to_cyc(T_ACCESS_NS,     CLK_PERIOD_NS);
    localparam int CYC_REL    = ns_to_cyc(T_RELEASE_NS,    CLK_PERIOD_NS);

    // Phase durations, each at least one cycle
    localparam int DUR_WR_PRE  = imax(1, CYC_RW_SU);
    localparam int DUR_WR_LOW  = imax(1, imax(CYC_CS_LO, CYC_D_SU));
    localparam int DUR_WR_HOLD = imax(1, imax(CYC_RW_HD, CYC_D_HD));
    localparam int DUR_RD_PRE  = imax(1, imax(CYC_RW_SU, CYC_RD_SU));
    localparam int DUR_RD_LOW  = imax(CYC_CS_LO, CYC_ACC + 1);
    localparam int DUR_RD_DONE = imax(1, CYC_RW_HD);

    // Idle gaps after each cycle kind
    localparam int GAP_WR = CYC_CS_HI;
    localparam int GAP_RD = imax(CYC_CS_HI, CYC_REL);

    localparam int MAX_DUR = imax(imax(imax(DUR_WR_PRE, DUR_WR_LOW), imax(DUR_WR_HOLD, DUR_RD_PRE)),
                                  imax(DUR_RD_LOW, DUR_RD_DONE));
    localparam int TMR_W   = bits_for(MAX_DUR - 1);
    localparam int GAP_W   = bits_for(GAP_RD);

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic              accept;
    logic              tmr_zero;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              gap_zero;
    logic              gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              wr_commit;
    logic              rd_capture;
    logic [DATA_W-1:0] wdata_q;

    assign accept = cmd_valid && cmd_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = cmd_write ? ST_WR_PRE : ST_RD_PRE;
            end
            ST_WR_PRE:  if (tmr_zero) state_d = ST_WR_LOW;
            ST_WR_LOW:  if (tmr_zero) state_d = ST_WR_HOLD;
            ST_WR_HOLD: if (tmr_zero) state_d = ST_IDLE;
            ST_RD_PRE:  if (tmr_zero) state_d = ST_RD_LOW;
            ST_RD_LOW:  if (tmr_zero) state_d = ST_RD_DONE;
            ST_RD_DONE: if (tmr_zero) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Phase timer load on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_WR_PRE:  tmr_val = TMR_W'(DUR_WR_PRE  - 1);
            ST_WR_LOW:  tmr_val = TMR_W'(DUR_WR_LOW  - 1);
            ST_WR_HOLD: tmr_val = TMR_W'(DUR_WR_HOLD - 1);
            ST_RD_PRE:  tmr_val = TMR_W'(DUR_RD_PRE  - 1);
            ST_RD_LOW:  tmr_val = TMR_W'(DUR_RD_LOW  - 1);
            ST_RD_DONE: tmr_val = TMR_W'(DUR_RD_DONE - 1);
            default:    tmr_val = '0;
        endcase
    end

    // Gap counter load when a cycle returns to idle
    always_comb begin
        gap_load = (state_d == ST_IDLE) && (state_q != ST_IDLE);
        gap_val  = (state_q == ST_RD_DONE) ? GAP_W'(GAP_RD) : GAP_W'(GAP_WR);
    end

    dac_bus_timer #(.W(TMR_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dac_bus_timer #(.W(GAP_W)) u_gap_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    // Write data holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (accept && cmd_write) begin
            wdata_q <= cmd_data;
        end
    end

    assign wr_commit  = (state_q == ST_WR_LOW) && tmr_zero;
    assign rd_capture = (state_q == ST_RD_LOW) && tmr_zero;

    dac_bus_readback #(.DATA_W(DATA_W)) u_readback (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (wr_commit),
        .commit_data  (wdata_q),
        .capture      (rd_capture),
        .bus_data     (dac_db_in),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_mismatch (rsp_mismatch)
    );

    // Port outputs decoded from the state
    always_comb begin
        dac_cs_n  = 1'b1;
        dac_rw    = 1'b1;
        dac_db_oe = 1'b0;
        cmd_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:    cmd_ready = gap_zero;
            ST_WR_PRE:  begin dac_rw = 1'b0; dac_db_oe = 1'b1; end
            ST_WR_LOW:  begin dac_rw = 1'b0; dac_db_oe = 1'b1; dac_cs_n = 1'b0; end
            ST_WR_HOLD: begin dac_rw = 1'b0; dac_db_oe = 1'b1; end
            ST_RD_PRE:  dac_rw = 1'b1;
            ST_RD_LOW:  dac_cs_n = 1'b0;
            ST_RD_DONE: dac_rw = 1'b1;
            default:    cmd_ready = 1'b0;
        endcase
    end

    assign dac_db_out = wdata_q;

endmodule

// File: rtl/dac_bus_ctrl_sva.sv
`timescale 1ns/1ps
module dac_bus_ctrl_sva #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              dac_cs_n,
    input logic              dac_rw,
    input logic [DATA_W-1:0] dac_db_out,
    input logic              dac_db_oe
);

    a_r2_rw_stable_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && !$past(dac_cs_n)) |-> (dac_rw == $past(dac_rw)));

    a_r2_data_stable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && !dac_rw && !$past(dac_cs_n)) |-> $stable(dac_db_out));

    a_r2_rw_held_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (dac_rw == $past(dac_rw)));

    a_r3_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_rw) |-> !dac_db_oe);

    a_r3_released_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dac_cs_n) && dac_rw) |-> !$past(dac_db_oe));

    a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (dac_cs_n && !$past(dac_cs_n) && $past(dac_rw)));

    a_r4_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r6_ready_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (dac_cs_n && !dac_db_oe));

    a_r7_no_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_cs_n) && dac_rw) |=> !dac_db_oe);

endmodule

bind dac_bus_ctrl dac_bus_ctrl_sva #(.DATA_W(DATA_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .dac_cs_n   (dac_cs_n),
    .dac_rw     (dac_rw),
    .dac_db_out (dac_db_out),
    .dac_db_oe  (dac_db_oe)
);

// File: tb/dac_bus_ctrl_tb.sv
`timescale 1ns/1ps
// Behavioural converter port: register, access delay, bus release window.
module dac_dev_model #(
    parameter int DW  = 12,
    parameter int ACC = 2,
    parameter int REL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rw,
    input  logic [DW-1:0] din,
    input  logic          flip,
    input  logic [DW-1:0] flip_mask,
    output logic [DW-1:0] dout,
    output logic          driving,
    output logic [DW-1:0] reg_q
);
    int lowc;
    int relc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
            lowc  <= 0;
            relc  <= 0;
        end else begin
            if (flip) reg_q <= reg_q ^ flip_mask;
            else if (!cs_n && !rw) reg_q <= din;
            lowc <= cs_n ? 0 : lowc + 1;
            if (!cs_n && rw) relc <= REL;
            else if (relc != 0) relc <= relc - 1;
        end
    end

    assign driving = (!cs_n && rw) || (relc != 0);
    assign dout    = !driving ? '0 : ((!cs_n && lowc >= ACC) ? reg_q : ~reg_q);
endmodule

module dac_bus_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        sel = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [11:0] cmd_data = '0;
    logic        flip = 1'b0;
    logic [11:0] flip_mask = '0;

    logic rdy0, rv0, mm0, cs0, rw0, oe0, drv0;
    logic [11:0] rd0, do0, di0, mreg0;
    logic rdy1, rv1, mm1, cs1, rw1, oe1, drv1;
    logic [7:0] rd1, do1, di1, mreg1;

    dac_bus_ctrl #(.DATA_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid && !sel), .cmd_ready(rdy0),
        .cmd_write(cmd_write), .cmd_data(cmd_data), .rsp_valid(rv0), .rsp_data(rd0),
        .rsp_mismatch(mm0), .dac_cs_n(cs0), .dac_rw(rw0), .dac_db_out(do0),
        .dac_db_oe(oe0), .dac_db_in(di0)
    );
    dac_dev_model #(.DW(12), .ACC(2), .REL(1)) u_dev (
        .clk(clk), .rst_n(rst_n), .cs_n(cs0), .rw(rw0), .din(do0), .flip(flip && !sel),
        .flip_mask(flip_mask), .dout(di0), .driving(drv0), .reg_q(mreg0)
    );

    dac_bus_ctrl #(.DATA_W(8), .CLK_PERIOD_NS(5)) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid && sel), .cmd_ready(rdy1),
        .cmd_write(cmd_write), .cmd_data(cmd_data[7:0]), .rsp_valid(rv1), .rsp_data(rd1),
        .rsp_mismatch(mm1), .dac_cs_n(cs1), .dac_rw(rw1), .dac_db_out(do1),
        .dac_db_oe(oe1), .dac_db_in(di1)
    );
    dac_dev_model #(.DW(8), .ACC(5), .REL(2)) u_dev_fast (
        .clk(clk), .rst_n(rst_n), .cs_n(cs1), .rw(rw1), .din(do1), .flip(flip && sel),
        .flip_mask(flip_mask[7:0]), .dout(di1), .driving(drv1), .reg_q(mreg1)
    );

    logic m_ready, m_rv, m_mm, m_cs_n, m_rw, m_oe;
    logic [11:0] m_rd, m_do, m_reg;
    assign m_ready = sel ? rdy1 : rdy0;
    assign m_rv    = sel ? rv1  : rv0;
    assign m_mm    = sel ? mm1  : mm0;
    assign m_cs_n  = sel ? cs1  : cs0;
    assign m_rw    = sel ? rw1  : rw0;
    assign m_oe    = sel ? oe1  : oe0;
    assign m_rd    = sel ? {4'b0, rd1}   : rd0;
    assign m_do    = sel ? {4'b0, do1}   : do0;
    assign m_reg   = sel ? {4'b0, mreg1} : mreg0;

    int n_chk = 0;
    int n_fail = 0;
    int n_cont = 0;
    bit finished = 0;

    always @(negedge clk) if ((oe0 && drv0) || (oe1 && drv1)) n_cont++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor results of the last command
    int   mon_low, mon_rsp_cnt;
    logic mon_pre_oe, mon_pre_rw, mon_rw_bad, mon_db_chg, mon_rise_rw;
    logic mon_rsp_pos, mon_busy_ready, mon_rsp_mm;
    logic [11:0] mon_rsp_data;

    task automatic run_cmd(input logic wr, input logic [11:0] d);
        logic seen, prev_low, last_oe, last_rw, first_rw;
        logic [11:0] first_db;
        mon_low = 0; mon_rsp_cnt = 0; mon_pre_oe = 0; mon_pre_rw = 0;
        mon_rw_bad = 0; mon_db_chg = 0; mon_rise_rw = 0; mon_rsp_pos = 0;
        mon_busy_ready = 0; mon_rsp_mm = 0; mon_rsp_data = '0;
        seen = 0; prev_low = 0; first_rw = 0; first_db = '0;
        @(negedge clk);
        cmd_write = wr; cmd_data = d; cmd_valid = 1'b1;
        while (!m_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        last_oe = m_oe; last_rw = m_rw;
        for (int i = 0; i < 60; i++) begin
            if (!m_cs_n) begin
                if (!seen) begin
                    mon_pre_oe = last_oe; mon_pre_rw = last_rw;
                    first_rw = m_rw; first_db = m_do;
                end else begin
                    if (m_rw != first_rw) mon_rw_bad = 1;
                    if (!m_rw && m_do != first_db) mon_db_chg = 1;
                end
                seen = 1;
                mon_low++;
            end
            if (m_cs_n && prev_low) mon_rise_rw = m_rw;
            if (m_rv) begin
                mon_rsp_cnt++;
                mon_rsp_data = m_rd; mon_rsp_mm = m_mm;
                if (prev_low && m_cs_n) mon_rsp_pos = 1;
            end
            if (m_ready) begin
                if (seen) break;
                mon_busy_ready = 1;
            end
            last_oe = m_oe; last_rw = m_rw; prev_low = !m_cs_n;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        chk("R1 cs_n after reset", m_cs_n, 1);
        chk("R1 rw after reset", m_rw, 1);
        chk("R1 oe after reset", m_oe, 0);
        chk("R1 ready after reset", m_ready, 1);
        chk("R1 rsp_valid after reset", m_rv, 0);
    endtask

    task automatic t_write(input logic [11:0] d, input int exp_low);
        run_cmd(1'b1, d);
        chk("R2 oe before select", mon_pre_oe, 1);
        chk("R2 rw low before select", mon_pre_rw, 0);
        chk("R2 select low cycles", mon_low, exp_low);
        chk("R2 rw stable while selected", mon_rw_bad, 0);
        chk("R2 data stable while selected", mon_db_chg, 0);
        chk("R2 rw held at rise", mon_rise_rw, 0);
        chk("R2 device register", m_reg, d);
        chk("R6 ready low during write", mon_busy_ready, 0);
        chk("R4 no response on write", mon_rsp_cnt, 0);
    endtask

    task automatic t_read(input logic [11:0] exp, input logic exp_mm, input int exp_low);
        run_cmd(1'b0, '0);
        chk("R3 bus released before select", mon_pre_oe, 0);
        chk("R3 rw high before select", mon_pre_rw, 1);
        chk("R3 select low cycles", mon_low, exp_low);
        chk("R4 one response pulse", mon_rsp_cnt, 1);
        chk("R4 response right after rise", mon_rsp_pos, 1);
        chk("R4 response data", mon_rsp_data, exp);
        chk("R5 mismatch flag", mon_rsp_mm, exp_mm);
        chk("R6 ready low during read", mon_busy_ready, 0);
    endtask

    task automatic t_turnaround(input logic [11:0] v, input int exp_gap);
        logic seen;
        int   cnt;
        seen = 0; cnt = 0;
        @(negedge clk);
        cmd_write = 1'b0; cmd_valid = 1'b1;
        while (!m_ready) @(negedge clk);
        @(negedge clk);
        cmd_write = 1'b1; cmd_data = v;
        for (int i = 0; i < 60; i++) begin
            if (!m_cs_n) seen = 1;
            else if (seen) begin
                if (m_oe) break;
                cnt++;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk("R7 read-to-write turnaround", cnt, exp_gap);
        for (int i = 0; i < 60; i++) begin
            if (m_ready) break;
            @(negedge clk);
        end
        chk("R2 write after turnaround", m_reg, v);
    endtask

    task automatic t_corrupt(input logic [11:0] mask);
        @(negedge clk);
        flip_mask = mask; flip = 1'b1;
        @(negedge clk);
        flip = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sel = 1'b0;
        t_reset_state();
        t_read(12'h000, 1'b0, 3);                 // R1 shadow and register both zero
        t_write(12'hFFF, 1); t_read(12'hFFF, 1'b0, 3);
        t_write(12'h000, 1); t_read(12'h000, 1'b0, 3);
        t_write(12'hA5A, 1); t_read(12'hA5A, 1'b0, 3);
        t_write(12'h001, 1); t_read(12'h001, 1'b0, 3);  // R4 bit 0 is the LSB
        t_corrupt(12'h010);
        t_read(12'h011, 1'b1, 3);                 // R5 device differs from shadow
        t_read(12'h011, 1'b1, 3);
        t_write(12'h5A5, 1); t_read(12'h5A5, 1'b0, 3);
        t_turnaround(12'h3C3, 3);
        t_read(12'h3C3, 1'b0, 3);
        sel = 1'b1;                               // R8 faster clock period parameter
        @(negedge clk);
        chk("R1 fast instance ready", m_ready, 1);
        t_read(12'h000, 1'b0, 6);
        t_write(12'h0A5, 2); t_read(12'h0A5, 1'b0, 6);
        t_turnaround(12'h05A, 4);
        t_read(12'h05A, 1'b0, 6);
        chk("R7 no bus contention", n_cont, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule